// File: doc/BRIEF.md
# Modular Feedback Shift Register with Word Reorganisation

This block holds sixteen 31-bit cells whose values live in the integers modulo the prime 2^31-1. Each step moves every cell down by one position. The top cell receives a new value, which is a weighted sum of five tap cells taken modulo 2^31-1. Each weight is a power of two, so every product is a 31-bit rotation. The partial sums are combined with end-around carry addition.

The block has two modes. In initialisation mode, an external 31-bit word is added into the feedback after the taps. In work mode, that word is ignored.

Four 32-bit words are built combinationally from halves of selected cells. A downstream nonlinear stage consumes them before the shift in the same step. The surrounding logic must:
- load all sixteen cells in parallel,
- pulse the step strobe, and
- pick the mode on each step.

Top module: `modlfsr31`

## Requirements
- R1: Synchronous active-high reset clears all sixteen cells to zero, so all four output words read zero.
- R2: When load_en is high at a clock edge, cell i takes load_cells[31*i+30 : 31*i] for every i in 0..15. load_en takes priority over step_en in the same cycle.
- R3: When step_en is high and load_en is low, cell i takes the old cell i+1 for i in 0..14, and cell 15 takes the feedback value.
- R4: The work-mode feedback is built by starting with s0 and then adding, in this order, rot(s0,8), rot(s4,20), rot(s10,21), rot(s13,17) and rot(s15,15). Here rot(v,k) is a 31-bit left rotation, and each addition is a + b with any result above 2^31-1 reduced by subtracting 2^31-1.
- R5: With init_mode high, the injected word is added, using the same addition, after the last tap. With init_mode low, the injected word has no effect on any cell.
- R6: x0 = {s15[30:15], s14[15:0]}.
- R7: x1 = {s11[15:0], s9[30:15]}, x2 = {s7[15:0], s5[30:15]} and x3 = {s2[15:0], s0[30:15]}.
- R8: With both load_en and step_en low, no cell changes, whatever values inject and init_mode carry.
- R9: The output words are combinational on the present cells. They show the new state in the same cycle after the edge that updated it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Parallel load strobe |
| load_cells | input | 496 | Load values; cell i occupies bits 31*i+30 to 31*i |
| step_en | input | 1 | Step strobe |
| init_mode | input | 1 | 1 selects initialisation mode, 0 selects work mode |
| inject | input | 31 | Word added to the feedback in initialisation mode |
| x0 | output | 32 | Reorganised word 0 |
| x1 | output | 32 | Reorganised word 1 |
| x2 | output | 32 | Reorganised word 2 |
| x3 | output | 32 | Reorganised word 3 |

## Verification
The bench loads all cells with 2^31-1, the alternate representation of zero. A design with a plain carry-drop adder, or with a modular adder that normalises that value, would produce a different top cell on that load.

Work-mode steps are driven with a non-zero inject word. A design that leaks the injected word into the feedback would diverge on those steps.

The bench asserts load and step together. A design with the wrong priority would shift instead of loading.

Long random runs in both modes catch any wrong rotation amount, a wrong tap or a wrong half-word selection. Any of these corrupts the words within a few steps.

// File: rtl/modlfsr31_pkg.sv
package modlfsr31_pkg;

    localparam int CELL_W  = 31;
    localparam int N_CELLS = 16;
    localparam int X_W     = 32;
    localparam int HALF_W  = X_W / 2;
    localparam int N_TAPS  = 5;
    localparam int FLAT_W  = CELL_W * N_CELLS;

    // Tap positions and their power-of-two weights, applied in this order.
    localparam int TAP_IDX [N_TAPS] = '{0, 4, 10, 13, 15};
    localparam int TAP_ROT [N_TAPS] = '{8, 20, 21, 17, 15};

    typedef logic [CELL_W-1:0] cell_t;

    typedef enum logic {
        MODE_WORK = 1'b0,
        MODE_INIT = 1'b1
    } mode_e;

    typedef struct packed {
        logic [X_W-1:0] w0;
        logic [X_W-1:0] w1;
        logic [X_W-1:0] w2;
        logic [X_W-1:0] w3;
    } xwords_t;

    // Multiplication by 2^k modulo 2^31-1: a 31-bit left rotation.
    function automatic cell_t rotl(cell_t v, int unsigned k);
        return (v << k) | (v >> (CELL_W - k));
    endfunction

    // Addition modulo 2^31-1 with end-around carry.
    function automatic cell_t add_mod(cell_t a, cell_t b);
        logic [CELL_W:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[CELL_W-1:0] + {{(CELL_W-1){1'b0}}, s[CELL_W]};
    endfunction

endpackage

// File: rtl/modlfsr31_addstage.sv
module modlfsr31_addstage
    import modlfsr31_pkg::*;
#(
    parameter int ROT = 0
) (
    input  cell_t acc_i,
    input  cell_t tap_i,
    output cell_t sum_o
);
    assign sum_o = add_mod(acc_i, rotl(tap_i, ROT));
endmodule

// File: rtl/modlfsr31_tapsum.sv
module modlfsr31_tapsum
    import modlfsr31_pkg::*;
(
    input  cell_t cells_i [N_CELLS],
    input  mode_e mode_i,
    input  cell_t inject_i,
    output cell_t fb_o
);
    cell_t partial [N_TAPS+1];

    assign partial[0] = cells_i[0];

    for (genvar t = 0; t < N_TAPS; t++) begin : g_tap
        modlfsr31_addstage #(.ROT(TAP_ROT[t])) u_stage (
            .acc_i (partial[t]),
            .tap_i (cells_i[TAP_IDX[t]]),
            .sum_o (partial[t+1])
        );
    end

    always_comb begin
        if (mode_i == MODE_INIT) fb_o = add_mod(partial[N_TAPS], inject_i);
        else                     fb_o = partial[N_TAPS];
    end
endmodule

// File: rtl/modlfsr31_reorg.sv
module modlfsr31_reorg
    import modlfsr31_pkg::*;
(
    input  cell_t   cells_i [N_CELLS],
    output xwords_t xw_o
);
    function automatic logic [X_W-1:0] pair(cell_t hi_src, cell_t lo_src);
        return {hi_src[HALF_W-1:0], lo_src[CELL_W-1:CELL_W-HALF_W]};
    endfunction

    always_comb begin
        xw_o.w0 = {cells_i[15][CELL_W-1:CELL_W-HALF_W], cells_i[14][HALF_W-1:0]};
        xw_o.w1 = pair(cells_i[11], cells_i[9]);
        xw_o.w2 = pair(cells_i[7],  cells_i[5]);
        xw_o.w3 = pair(cells_i[2],  cells_i[0]);
    end
endmodule

// File: rtl/modlfsr31.sv
module modlfsr31
    import modlfsr31_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load_en,
    input  logic [FLAT_W-1:0] load_cells,
    input  logic              step_en,
    input  logic              init_mode,
    input  logic [CELL_W-1:0] inject,
    output logic [X_W-1:0]    x0,
    output logic [X_W-1:0]    x1,
    output logic [X_W-1:0]    x2,
    output logic [X_W-1:0]    x3
);
    cell_t             cell_q [N_CELLS];
    cell_t             fb;
    mode_e             mode_sel;
    xwords_t           xw;
    logic [FLAT_W-1:0] cell_flat;

    assign mode_sel = init_mode ? MODE_INIT : MODE_WORK;

    modlfsr31_tapsum u_tapsum (
        .cells_i  (cell_q),
        .mode_i   (mode_sel),
        .inject_i (inject),
        .fb_o     (fb)
    );

    modlfsr31_reorg u_reorg (
        .cells_i (cell_q),
        .xw_o    (xw)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_CELLS; i++) cell_q[i] <= '0;
        end else if (load_en) begin
            for (int i = 0; i < N_CELLS; i++) cell_q[i] <= load_cells[i*CELL_W +: CELL_W];
        end else if (step_en) begin
            for (int i = 0; i < N_CELLS-1; i++) cell_q[i] <= cell_q[i+1];
            cell_q[N_CELLS-1] <= fb;
        end
    end

    for (genvar i = 0; i < N_CELLS; i++) begin : g_flat
        assign cell_flat[i*CELL_W +: CELL_W] = cell_q[i];
    end

    assign x0 = xw.w0;
    assign x1 = xw.w1;
    assign x2 = xw.w2;
    assign x3 = xw.w3;
endmodule

// File: rtl/modlfsr31_chk.sv
module modlfsr31_chk
    import modlfsr31_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              load_en,
    input logic              step_en,
    input logic [FLAT_W-1:0] load_cells,
    input logic [FLAT_W-1:0] cell_flat,
    input logic [X_W-1:0]    x3
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (cell_flat == '0));

    assert_load_all_R2: assert property (@(posedge clk) disable iff (rst)
        load_en |=> (cell_flat == $past(load_cells)));

    assert_shift_down_R3: assert property (@(posedge clk) disable iff (rst)
        (step_en && !load_en) |=>
            (cell_flat[FLAT_W-CELL_W-1:0] == $past(cell_flat[FLAT_W-1:CELL_W])));

    assert_hold_idle_R8: assert property (@(posedge clk) disable iff (rst)
        (!step_en && !load_en) |=> $stable(cell_flat));

    // R7: after a shift, the upper half of x3 shows the old cell 3 low half.
    assert_x3_track_R7: assert property (@(posedge clk) disable iff (rst)
        (step_en && !load_en) |=>
            (x3[X_W-1:HALF_W] == $past(cell_flat[3*CELL_W +: HALF_W])));
endmodule

bind modlfsr31 modlfsr31_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .load_en    (load_en),
    .step_en    (step_en),
    .load_cells (load_cells),
    .cell_flat  (cell_flat),
    .x3         (x3)
);

// File: tb/modlfsr31_bench.sv
module modlfsr31_bench;
    localparam int W  = 31;
    localparam int N  = 16;
    localparam int FW = W * N;
    localparam logic [W-1:0] P = 31'h7FFFFFFF;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          load_en = 1'b0;
    logic [FW-1:0] load_cells = '0;
    logic          step_en = 1'b0;
    logic          init_mode = 1'b0;
    logic [W-1:0]  inject = '0;
    logic [31:0]   x0, x1, x2, x3;

    int tests = 0;
    int fails = 0;
    logic [W-1:0] m [N];

    always #2 clk = ~clk;

    modlfsr31 u_modlfsr31 (
        .clk(clk), .rst(rst), .load_en(load_en), .load_cells(load_cells),
        .step_en(step_en), .init_mode(init_mode), .inject(inject),
        .x0(x0), .x1(x1), .x2(x2), .x3(x3)
    );

    function automatic logic [W-1:0] b_rot(logic [W-1:0] v, int k);
        logic [2*W-1:0] d;
        d = {v, v};
        return d[2*W-1-k -: W];
    endfunction

    function automatic logic [W-1:0] b_add(logic [W-1:0] a, logic [W-1:0] b);
        logic [31:0] t;
        t = {1'b0, a} + {1'b0, b};
        if (t > {1'b0, P}) t = t - {1'b0, P};
        return t[W-1:0];
    endfunction

    function automatic logic [W-1:0] b_fb(logic md, logic [W-1:0] u);
        logic [W-1:0] f;
        f = m[0];
        f = b_add(f, b_rot(m[0], 8));
        f = b_add(f, b_rot(m[4], 20));
        f = b_add(f, b_rot(m[10], 21));
        f = b_add(f, b_rot(m[13], 17));
        f = b_add(f, b_rot(m[15], 15));
        if (md) f = b_add(f, u);
        return f;
    endfunction

    task automatic chk(string tag, string nm, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, nm, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        chk(tag, "x0(R6)", x0, {m[15][30:15], m[14][15:0]});
        chk(tag, "x1(R7)", x1, {m[11][15:0], m[9][30:15]});
        chk(tag, "x2(R7)", x2, {m[7][15:0], m[5][30:15]});
        chk(tag, "x3(R7)", x3, {m[2][15:0], m[0][30:15]});
    endtask

    task automatic cyc(logic ld, logic st, logic md, logic [W-1:0] u,
                       logic [FW-1:0] data, string tag);
        logic [W-1:0] f;
        @(negedge clk);
        load_en = ld; step_en = st; init_mode = md; inject = u; load_cells = data;
        @(posedge clk);
        if (ld) begin
            for (int i = 0; i < N; i++) m[i] = data[i*W +: W];
        end else if (st) begin
            f = b_fb(md, u);
            for (int i = 0; i < N-1; i++) m[i] = m[i+1];
            m[N-1] = f;
        end
        #1;
        check_all(tag);
    endtask

    function automatic logic [FW-1:0] rand_load();
        logic [FW-1:0] d;
        for (int i = 0; i < N; i++) d[i*W +: W] = W'($urandom) & P;
        return d;
    endfunction

    initial begin : watchdog
        #(4 * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : main
        logic [FW-1:0] d;
        int r;
        void'($urandom(32'd7741));
        for (int i = 0; i < N; i++) m[i] = '0;
        repeat (3) @(posedge clk);
        #1;
        check_all("R1 reset");
        @(negedge clk);
        rst = 1'b0;

        // R2: load with step asserted: load must win
        d = rand_load();
        cyc(1'b1, 1'b1, 1'b1, 31'h1234567, d, "R2 load priority");
        // R9: outputs reflect the new cells right after the edge
        cyc(1'b0, 1'b1, 1'b0, 31'h0, '0, "R9 same-cycle step");

        // R8: idle with changing inject and mode
        for (int i = 0; i < 4; i++)
            cyc(1'b0, 1'b0, i[0], W'($urandom), '0, "R8 idle hold");

        // R4: all cells 2^31-1 (alternate zero)
        d = {N{P}};
        cyc(1'b1, 1'b0, 1'b0, '0, d, "R2 load all-ones");
        for (int i = 0; i < 3; i++) cyc(1'b0, 1'b1, 1'b0, '0, '0, "R4 all-ones work step");

        // R5: zero cells, init mode with maximal inject
        cyc(1'b1, 1'b0, 1'b0, '0, '0, "R2 load zero");
        cyc(1'b0, 1'b1, 1'b1, P, '0, "R5 init inject max");
        cyc(1'b0, 1'b1, 1'b1, 31'h1, '0, "R5 init inject one");

        // R5: work mode ignores a nonzero inject
        d = rand_load();
        cyc(1'b1, 1'b0, 1'b0, '0, d, "R2 load random");
        for (int i = 0; i < 16; i++)
            cyc(1'b0, 1'b1, 1'b0, W'($urandom) | 31'h1, '0, "R5 work ignores inject");

        // R3/R4/R5: 32 initialisation steps then random mixed traffic
        d = rand_load();
        cyc(1'b1, 1'b0, 1'b0, '0, d, "R2 load random");
        for (int i = 0; i < 32; i++)
            cyc(1'b0, 1'b1, 1'b1, W'($urandom) & P, '0, "R3 init steps");
        for (int i = 0; i < 900; i++) begin
            r = $urandom_range(0, 99);
            if (r < 4)       cyc(1'b1, r[0], 1'b0, '0, rand_load(), "R2 random load");
            else if (r < 12) cyc(1'b0, 1'b0, r[0], W'($urandom), '0, "R8 random idle");
            else             cyc(1'b0, 1'b1, r[1], W'($urandom) & P, '0, "R4 random step");
        end

        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        for (int i = 0; i < N; i++) m[i] = '0;
        #1;
        check_all("R1 reset after run");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule